// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock for an SD or MMC host from a fast base clock. Two dividers sit in series. The first is a power-of-two prescaler and the second is a linear divisor of 1 to 16. The output period in base cycles is the product of the two ratios. The block gives a level clock and a one-cycle strobe that marks the start of each output period. It also raises a flag once the new rate has settled.

Software programs the block through a single control word. It sets the prescaler code, the divisor code and two enable bits: a card-clock enable and a peripheral-clock enable. A rate change follows a fixed sequence. First the card-clock enable is cleared. The output then finishes its current high phase and parks low. The new codes are then written together with both enables, and the clock restarts at the start of a period. After reset the block runs at an identification rate. That rate is worked out at elaboration from the base frequency and a target of 400 kHz. The choice of codes for any other rate belongs to software.

Top module: `sd_card_clkdiv`

## Requirements
- R1: While reset is held, `card_clk`, `clk_strobe` and `clk_stable` are low. The control word resets to the identification codes with both enables set, so the clock starts right after reset. The period equals P*D, where P is the smallest power of two from 2 to 256 with BASE_HZ/P <= 16*ID_HZ (P stays 2 when BASE_HZ/16 <= ID_HZ), and D is the smallest ratio from 1 to 16 with BASE_HZ/(P*D) <= ID_HZ.
- R2: The output period is P*D base cycles. P comes from the prescaler code in control bits 15:8, which holds P/2 for P in 2, 4, ..., 256.
- R3: A prescaler code of 0 gives P = 1 (bypass). A code with several bits set acts as its highest set bit alone; for example 0x03 gives P = 4 and 0xC0 gives P = 256.
- R4: The divisor code in control bits 7:4 holds D-1, so the codes 0 to 15 select D = 1 to 16.
- R5: In each period of N = P*D cycles, `card_clk` is high for the first ceil(N/2) cycles and low for the rest. `clk_strobe` is high in the first cycle of each period only. For N = 1 both stay high.
- R6: On a write to the control word while the card-clock enable (bit 1) is set, the prescaler and divisor codes are discarded. The two enable bits of that write still take effect.
- R7: When the card-clock enable (bit 1) or the peripheral-clock enable (bit 0) is cleared, a high phase in progress runs to its full length. After that `card_clk` and `clk_strobe` stay low.
- R8: The clock runs only while both enables are set. A restart begins at the start of a period, with a full high phase, and uses the codes most recently accepted.
- R9: `clk_stable` is low while the clock is stopped and through the first two periods after a start. It rises in the same cycle as the third strobe, stays high while the clock runs, and falls when the clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8+PRE_W | Control word: prescaler code [15:8], divisor code [7:4], card enable [1], peripheral enable [0] |
| card_clk | output | 1 | Divided card clock level |
| clk_strobe | output | 1 | One base cycle at the start of each output period |
| clk_stable | output | 1 | Clock has run two full periods at its current setting |

## Verification
The in-RTL properties check on every cycle the following:
- the strobe never appears while the clock is low;
- the counters stay inside the ratio that is loaded;
- the codes cannot move while the card enable is set;
- a stopping clock never goes high again;
- the stable flag can only rise on a strobe.

The exact period and duty cycle for each code pair can only be shown by the bench's sweep. The same holds for the way codes map to ratios, including bypass and multi-bit prescaler codes. The bench scenarios also show that the high phase in progress at a disable keeps its full length, that a restart picks up only accepted codes, and that the flag waits for the third strobe.

// File: rtl/sd_clkdiv_pkg.sv
package sd_clkdiv_pkg;

   typedef enum logic {
      CK_HALTED  = 1'b0,
      CK_RUNNING = 1'b1
   } ck_state_e;

   // Prescaler ratio used for the identification rate after reset.
   function automatic int unsigned ident_pre_ratio(longint unsigned base_hz,
                                                   longint unsigned ident_hz);
      int unsigned p;
      p = 2;
      if ((base_hz / 16) > ident_hz) begin
         for (int k = 0; k < 7; k++) begin
            if ((base_hz / p) > (ident_hz * 16)) p = p * 2;
         end
      end
      return p;
   endfunction

   // Divisor ratio (1..16) for the identification rate given the prescaler.
   function automatic int unsigned ident_div_ratio(longint unsigned base_hz,
                                                   longint unsigned ident_hz,
                                                   int unsigned pre);
      int unsigned d;
      d = 16;
      for (int k = 16; k >= 1; k--) begin
         if ((base_hz / (longint'(k) * pre)) <= ident_hz) d = k;
      end
      return d;
   endfunction

   // Shift amount of the prescaler: 0 for bypass, else highest set bit + 1.
   function automatic logic [3:0] pre_shift(logic [7:0] code);
      logic [3:0] s;
      s = 4'd0;
      for (int b = 0; b < 8; b++) begin
         if (code[b]) s = 4'(b + 1);
      end
      return s;
   endfunction

endpackage

// File: rtl/sd_clkdiv_ctrl.sv
module sd_clkdiv_ctrl #(
   parameter int PRE_W        = 8,
   parameter int DIV_W        = 4,
   parameter int RST_PRE_CODE = 4,
   parameter int RST_DIV_CODE = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [8+PRE_W-1:0] wr_data,
   output logic [PRE_W-1:0]   pre_code,
   output logic [DIV_W-1:0]   div_code,
   output logic               card_en,
   output logic               per_en,
   output logic               fields_take
);

   localparam int PRE_LSB = 8;
   localparam int DIV_LSB = 4;
   localparam int CEN_BIT = 1;
   localparam int PEN_BIT = 0;

   assign fields_take = wr_en && !card_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_code <= PRE_W'(RST_PRE_CODE);
         div_code <= DIV_W'(RST_DIV_CODE);
         card_en  <= 1'b1;
         per_en   <= 1'b1;
      end else if (wr_en) begin
         card_en <= wr_data[CEN_BIT];
         per_en  <= wr_data[PEN_BIT];
         if (!card_en) begin
            pre_code <= wr_data[PRE_LSB +: PRE_W];
            div_code <= wr_data[DIV_LSB +: DIV_W];
         end
      end
   end

   // R6: codes are frozen whenever the card clock enable was set
   assert_fields_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      card_en |=> ($stable(pre_code) && $stable(div_code)));

endmodule

// File: rtl/sd_clkdiv_prescale.sv
module sd_clkdiv_prescale #(
   parameter int PRE_W = 8,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   input  logic [EXP_W-1:0] shift,
   output logic [PRE_W-1:0] cnt_q,
   output logic [PRE_W-1:0] cnt_nat,
   output logic             tick
);

   logic [PRE_W:0] lim_w;

   assign lim_w   = ({{PRE_W{1'b0}}, 1'b1} << shift) - 1'b1;
   assign tick    = (cnt_q == lim_w[PRE_W-1:0]);
   assign cnt_nat = advance ? (tick ? '0 : cnt_q + 1'b1) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_nat;
   end

   // R2: prescaler count never leaves the loaded ratio
   assert_pre_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt_q} <= lim_w));

endmodule

// File: rtl/sd_clkdiv_divisor.sv
module sd_clkdiv_divisor #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   input  logic [DIV_W-1:0] ratio_m1,
   output logic [DIV_W-1:0] cnt_q,
   output logic [DIV_W-1:0] cnt_nat,
   output logic             wrap
);

   assign wrap    = (cnt_q == ratio_m1);
   assign cnt_nat = advance ? (wrap ? '0 : cnt_q + 1'b1) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_nat;
   end

   // R4: divisor count stays at or below the loaded code
   assert_div_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= ratio_m1));

endmodule

// File: rtl/sd_card_clkdiv.sv
module sd_card_clkdiv #(
   parameter longint unsigned BASE_HZ = 50_000_000,
   parameter longint unsigned ID_HZ   = 400_000,
   parameter int              PRE_W   = 8,
   parameter int              DIV_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [8+PRE_W-1:0] ctrl_wdata,
   output logic               card_clk,
   output logic               clk_strobe,
   output logic               clk_stable
);
   import sd_clkdiv_pkg::*;

   localparam int EXP_W        = $clog2(PRE_W + 1);
   localparam int PH_W         = PRE_W + DIV_W;
   localparam int N_W          = PH_W + 1;
   localparam int ID_PRE       = int'(ident_pre_ratio(BASE_HZ, ID_HZ));
   localparam int ID_DIV       = int'(ident_div_ratio(BASE_HZ, ID_HZ, ID_PRE));
   localparam int RST_PRE_CODE = ID_PRE / 2;
   localparam int RST_DIV_CODE = ID_DIV - 1;

   generate
      if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre
         $error("PRE_W must lie in 1..8");
      end
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("DIV_W must lie in 1..4");
      end
      if (RST_PRE_CODE >= (1 << PRE_W)) begin : g_bad_id
         $error("identification prescaler does not fit PRE_W");
      end
      if (ID_HZ == 0 || BASE_HZ < ID_HZ) begin : g_bad_hz
         $error("BASE_HZ must be at least ID_HZ and ID_HZ nonzero");
      end
   endgenerate

   // control word
   logic [PRE_W-1:0] pre_code;
   logic [DIV_W-1:0] div_code;
   logic             card_en, per_en, fields_take;

   sd_clkdiv_ctrl #(
      .PRE_W        (PRE_W),
      .DIV_W        (DIV_W),
      .RST_PRE_CODE (RST_PRE_CODE),
      .RST_DIV_CODE (RST_DIV_CODE)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ctrl_wr),
      .wr_data     (ctrl_wdata),
      .pre_code    (pre_code),
      .div_code    (div_code),
      .card_en     (card_en),
      .per_en      (per_en),
      .fields_take (fields_take)
   );

   // run state and active setting
   ck_state_e        run_q, run_d;
   logic [EXP_W-1:0] act_exp;
   logic [DIV_W-1:0] act_dm1;
   logic             reload_pend_q;
   logic [1:0]       wc_q, wc_d;
   logic             ck_q, stb_q, stable_q;
   logic             ck_d, stb_d, stable_d;

   logic             running, both_en, halt_req, start, stop, cnt_clear;
   logic [PRE_W-1:0] pre_cnt, pre_nat;
   logic             pre_tick;
   logic [DIV_W-1:0] div_cnt, div_nat;
   logic             div_wrap;
   logic [N_W-1:0]   ratio_n, half_n, phase_nat;
   logic             at_boundary;

   assign running   = (run_q == CK_RUNNING);
   assign both_en   = card_en && per_en;
   assign halt_req  = !both_en || reload_pend_q;
   assign start     = !running && both_en;
   assign cnt_clear = !running || stop;

   sd_clkdiv_prescale #(
      .PRE_W (PRE_W),
      .EXP_W (EXP_W)
   ) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clear),
      .advance (running),
      .shift   (act_exp),
      .cnt_q   (pre_cnt),
      .cnt_nat (pre_nat),
      .tick    (pre_tick)
   );

   sd_clkdiv_divisor #(
      .DIV_W (DIV_W)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cnt_clear),
      .advance  (running && pre_tick),
      .ratio_m1 (act_dm1),
      .cnt_q    (div_cnt),
      .cnt_nat  (div_nat),
      .wrap     (div_wrap)
   );

   // period length, high-phase length and the phase the counters reach next
   assign ratio_n     = (N_W'(act_dm1) + N_W'(1)) << act_exp;
   assign half_n      = (ratio_n + N_W'(1)) >> 1;
   assign phase_nat   = (N_W'(div_nat) << act_exp) | N_W'(pre_nat);
   assign at_boundary = (phase_nat == '0) || (phase_nat >= half_n);
   assign stop        = running && halt_req && at_boundary;

   always_comb begin
      run_d = run_q;
      wc_d  = wc_q;
      ck_d  = 1'b0;
      stb_d = 1'b0;
      if (start) begin
         run_d = CK_RUNNING;
         wc_d  = 2'd0;
         ck_d  = 1'b1;
         stb_d = 1'b1;
      end else if (stop) begin
         run_d = CK_HALTED;
         wc_d  = 2'd0;
      end else if (running) begin
         ck_d  = (phase_nat < half_n);
         stb_d = (phase_nat == '0);
         if (phase_nat == '0 && wc_q != 2'd2) wc_d = wc_q + 2'd1;
      end
      stable_d = (run_d == CK_RUNNING) && (wc_d == 2'd2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q         <= CK_HALTED;
         act_exp       <= '0;
         act_dm1       <= '0;
         reload_pend_q <= 1'b0;
         wc_q          <= 2'd0;
         ck_q          <= 1'b0;
         stb_q         <= 1'b0;
         stable_q      <= 1'b0;
      end else begin
         run_q    <= run_d;
         wc_q     <= wc_d;
         ck_q     <= ck_d;
         stb_q    <= stb_d;
         stable_q <= stable_d;
         if (start) begin
            act_exp       <= EXP_W'(pre_shift(8'(pre_code)));
            act_dm1       <= div_code;
            reload_pend_q <= 1'b0;
         end else if (fields_take) begin
            reload_pend_q <= 1'b1;
         end
      end
   end

   assign card_clk   = ck_q;
   assign clk_strobe = stb_q;
   assign clk_stable = stable_q;

   // R5: the period marker only coincides with a high clock
   assert_strobe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_strobe |-> card_clk);

   // R7: once stopping and already low, the clock never rises again
   assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && halt_req && !card_clk) |=> !card_clk);

   // R8: without both enables a halted clock stays halted
   assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !both_en) |=> (!card_clk && !clk_strobe));

   // R9: the settled flag can only rise at a period start
   assert_stable_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_stable) |-> clk_strobe);

endmodule

// File: tb/sd_card_clkdiv_tb_top.sv
module sd_card_clkdiv_tb_top;

   localparam longint unsigned BASE = 50_000_000;
   localparam longint unsigned IDF  = 400_000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ctrl_wr;
   logic [15:0] ctrl_wdata;
   logic        card_clk, clk_strobe, clk_stable;

   int errs   = 0;
   int checks = 0;
   int cur_n  = 0;

   always #2 clk = ~clk;

   sd_card_clkdiv #(
      .BASE_HZ (BASE),
      .ID_HZ   (IDF),
      .PRE_W   (8),
      .DIV_W   (4)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .card_clk   (card_clk),
      .clk_strobe (clk_strobe),
      .clk_stable (clk_stable)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   function automatic int pre_ratio(input int code);
      int r;
      r = 1;
      for (int b = 0; b < 8; b++) if (code[b]) r = 2 << b;
      return r;
   endfunction

   function automatic int ident_period();
      longint p, d;
      p = 2;
      if (BASE / 16 > IDF)
         while (p < 256 && BASE / p > IDF * 16) p = p * 2;
      d = 1;
      while (d < 16 && BASE / (p * d) > IDF) d = d + 1;
      return int'(p * d);
   endfunction

   function automatic logic [15:0] word(input int p, input int d,
                                        input bit cen, input bit pen);
      return {p[7:0], d[3:0], 2'b00, cen, pen};
   endfunction

   // called at a falling edge; the word is captured at the next rising edge
   task automatic wr_word(input logic [15:0] w);
      ctrl_wr    = 1'b1;
      ctrl_wdata = w;
      @(negedge clk);
      ctrl_wr    = 1'b0;
   endtask

   task automatic wait_strobe(output bit found);
      found = 1'b0;
      for (int i = 0; i < 9000; i++) begin
         @(negedge clk);
         if (clk_strobe) begin
            found = 1'b1;
            break;
         end
      end
   endtask

   task automatic measure(input int n_exp, input string req);
      bit found;
      int per, hi;
      wait_strobe(found);
      per = 0;
      hi  = 0;
      if (found) begin
         per = 1;
         hi  = card_clk ? 1 : 0;
         for (int i = 0; i < 9000; i++) begin
            @(negedge clk);
            if (clk_strobe) break;
            per++;
            if (card_clk) hi++;
         end
      end
      chk(per == n_exp, req, "period", per, n_exp);
      chk(hi == (n_exp + 1) / 2, "R5", "high cycles", hi, (n_exp + 1) / 2);
   endtask

   task automatic quiet(input int cycles, input string req);
      int seen;
      seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (card_clk || clk_strobe || clk_stable) seen++;
      end
      chk(seen == 0, req, "active samples while halted", seen, 0);
   endtask

   task automatic apply_cfg(input int p, input int d, input string req);
      int n;
      wr_word(word(p, d, 1'b0, 1'b1));
      repeat (cur_n + 3) @(negedge clk);
      wr_word(word(p, d, 1'b1, 1'b1));
      n     = pre_ratio(p) * (d + 1);
      cur_n = n;
      measure(n, req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      int pre_list[11] = '{0, 1, 2, 3, 4, 8, 16, 32, 64, 128, 192};
      int sc, bad, hc;
      bit st3, found;

      rst_n      = 1'b0;
      ctrl_wr    = 1'b0;
      ctrl_wdata = '0;
      repeat (5) @(negedge clk);
      // R1: outputs quiet in reset
      chk(!card_clk && !clk_strobe && !clk_stable, "R1", "outputs in reset",
          {card_clk, clk_strobe, clk_stable}, 0);
      rst_n = 1'b1;
      // R1: identification rate right after reset
      cur_n = ident_period();
      measure(cur_n, "R1");

      // R2 R3 R4: sweep of code pairs
      foreach (pre_list[k]) begin
         int p;
         p = pre_list[k];
         for (int d = 0; d < 16; d++) begin
            if (pre_ratio(p) > 4 && !(d == 0 || d == 1 || d == 15)) continue;
            if (p == 0 || p == 3 || p == 192) apply_cfg(p, d, "R3");
            else if (d == 15 || d == 0)       apply_cfg(p, d, "R4");
            else                              apply_cfg(p, d, "R2");
         end
      end

      // R9: flag timing after a restart at N=6
      wr_word(word(1, 2, 1'b0, 1'b1));
      repeat (cur_n + 3) @(negedge clk);
      wr_word(word(1, 2, 1'b1, 1'b1));
      cur_n = 6;
      sc  = 0;
      bad = 0;
      st3 = 1'b0;
      for (int i = 0; i < 200 && sc < 3; i++) begin
         @(negedge clk);
         if (clk_strobe) sc++;
         if (sc < 3 && clk_stable) bad++;
         if (sc == 3) st3 = clk_stable;
      end
      chk(bad == 0, "R9", "early stable samples", bad, 0);
      chk(st3, "R9", "stable at third strobe", int'(st3), 1);
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!clk_stable) bad++;
      end
      chk(bad == 0, "R9", "stable drops while running", bad, 0);

      // R6: code write while enabled is discarded
      wr_word(word(0, 0, 1'b1, 1'b1));
      measure(6, "R6");

      // R8: peripheral enable alone cleared halts; card-only off stays halted
      wr_word(word(1, 2, 1'b1, 1'b0));
      repeat (10) @(negedge clk);
      quiet(40, "R8");
      wr_word(word(1, 2, 1'b0, 1'b1));
      quiet(40, "R8");
      wr_word(word(1, 2, 1'b1, 1'b1));
      measure(6, "R8");

      // R7: disable at the start of a high phase of N=9 keeps the full phase
      apply_cfg(0, 8, "R4");
      wait_strobe(found);
      ctrl_wr    = 1'b1;
      ctrl_wdata = word(0, 8, 1'b0, 1'b1);
      hc = found ? 1 : 0;
      @(negedge clk);
      ctrl_wr = 1'b0;
      for (int i = 0; i < 100 && card_clk; i++) begin
         hc++;
         @(negedge clk);
      end
      chk(hc == 5, "R7", "high cycles across disable", hc, 5);
      quiet(40, "R7");
      chk(!clk_stable, "R9", "stable after stop", int'(clk_stable), 0);

      // R8: restart uses the newest accepted codes
      wr_word(word(2, 1, 1'b1, 1'b1));
      cur_n = 8;
      measure(8, "R8");

      finish_run();
   end

endmodule